// File: doc/BRIEF.md
# Timed Charge-Pump Correction Driver

This block sits at the end of a once-per-second frequency correction loop. A counter elsewhere measures the phase error against a pulse-per-second reference and delivers it as a signed number. The block turns each number into one drive pulse on a three-state charge-pump output. The pulse is high or low according to the sign of the error. Its length is a fixed number of milliseconds per error count. Between pulses the output is released to high impedance, so that the loop filter holds its charge.

After reset the block first runs a start-up phase of fixed length. During that phase it drives a symmetric square wave continuously, which pulls the filter capacitor towards mid-rail. Only after the phase ends does it begin to accept errors. Each accepted error must be enabled by a PPS tick that arrives after start-up. An indicator output is lit for the whole correction window. A zero error gives a short flash with no drive, so a locked loop still blinks once per second.

Errors arrive on a valid/ready interface. A beat transfers on a clock edge where `err_valid` and `err_ready` are both high. `err_ready` is high only while the block is armed by a PPS tick and no correction window is open. The block never stores a beat that has not transferred. A source may hold `err_valid` until it sees ready. A source that drops `err_valid` while ready is low has lost that value, which is how late errors are discarded.

Top module: `chargepump_pulse_ctrl`

## Requirements
- R1: From reset until INIT_MS milliseconds have passed, `pump_oe` is high and `pump_level` is a square wave. The square wave starts high and toggles every SQ_HALF_MS milliseconds. During this phase `led_on` and `err_ready` are low, and PPS ticks have no effect.
- R2: After start-up, `pump_oe` is high only during the drive part of a correction window.
- R3: `err_ready` rises only after a PPS tick that follows start-up, and it is low while a window is open. A PPS tick that arrives during a window re-arms the block when the window ends. Each PPS tick allows exactly one error to transfer.
- R4: A non-zero error e drives the pump for |e|*MS_PER_COUNT milliseconds, counted as whole prescaled millisecond ticks. The error is two's complement and ERR_W bits wide, so -128 gives 128 counts.
- R5: A positive error drives `pump_level` to POS_DRIVE_HIGH and a negative error drives it to the inverse. When the output is not being driven after start-up, `pump_level` reads 0.
- R6: A zero error drives nothing. It opens a window of MS_PER_COUNT milliseconds with `led_on` high and `pump_oe` low.
- R7: `led_on` is high for exactly the correction window. For a non-zero error that is the pump-drive time.
- R8: Without a PPS tick, a valid error is never taken, and neither the pump nor the LED is activated.
- R9: An error offered while a window is open is ignored. It does not change the running pulse and is not taken afterwards.
- R10: All timing uses a millisecond tick made by dividing the clock by CLKS_PER_MS. The prescaler restarts when a pulse starts, so a window lasts exactly the nominal number of milliseconds times CLKS_PER_MS clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pps_tick | input | 1 | One-cycle pulse-per-second tick |
| err_valid | input | 1 | Error beat valid |
| err_ready | output | 1 | Block can take an error beat |
| err_value | input | ERR_W | Signed phase error, two's complement |
| pump_level | output | 1 | Level driven onto the charge pump |
| pump_oe | output | 1 | Pump output enable; low means high impedance |
| led_on | output | 1 | Indicator LED drive |

## Verification
The bound checker watches a set of rules on every cycle:
- the pump is enabled only during start-up or inside a lit window;
- the indicator stays dark and ready stays low during start-up;
- ready and the indicator are never high together;
- every window opens on a transferred beat;
- a zero error never enables the pump;
- the drive level does not change within a pulse.

Some properties need the bench's scenarios to show them, because they depend on exact durations and counts:
- the pulse length for each error magnitude, including the -128 and +/-1 limits;
- the square-wave period and the length of start-up;
- that errors offered without a PPS tick, or during a pulse, are dropped;
- that a tick which arrives mid-pulse re-arms the block.

// File: rtl/cp_pkg.sv
package cp_pkg;

  typedef enum logic [1:0] {
    CP_START  = 2'd0,
    CP_WAIT   = 2'd1,
    CP_ARMED  = 2'd2,
    CP_PULSE  = 2'd3
  } cp_phase_e;

  function automatic int unsigned cp_width(input int unsigned max_val);
    return (max_val > 1) ? $clog2(max_val + 1) : 1;
  endfunction

endpackage

// File: rtl/cp_ms_prescale.sv
module cp_ms_prescale #(
  parameter int unsigned CLKS_PER_MS = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic ms_tick
);
  generate
    if (CLKS_PER_MS <= 1) begin : g_pass
      assign ms_tick = 1'b1;
    end else begin : g_div
      localparam int unsigned CW = $clog2(CLKS_PER_MS);
      localparam logic [CW-1:0] LAST = CW'(CLKS_PER_MS - 1);
      logic [CW-1:0] cnt_q;

      assign ms_tick = (cnt_q == LAST);

      always_ff @(posedge clk) begin
        if (!rst_n || restart || ms_tick) cnt_q <= '0;
        else                              cnt_q <= cnt_q + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/cp_start_seq.sv
module cp_start_seq #(
  parameter int unsigned CLKS_PER_MS = 10000,
  parameter int unsigned INIT_MS     = 20000,
  parameter int unsigned SQ_HALF_MS  = 250
) (
  input  logic clk,
  input  logic rst_n,
  output logic busy,
  output logic square
);
  localparam int unsigned IW = cp_pkg::cp_width(INIT_MS);
  localparam int unsigned HW = cp_pkg::cp_width(SQ_HALF_MS);
  localparam logic [IW-1:0] INIT_LAST = IW'(INIT_MS - 1);
  localparam logic [HW-1:0] HALF_LAST = HW'(SQ_HALF_MS - 1);

  logic          tick;
  logic [IW-1:0] ms_q;
  logic [HW-1:0] half_q;

  cp_ms_prescale #(.CLKS_PER_MS(CLKS_PER_MS)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (1'b0),
    .ms_tick (tick)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b1;
      square <= 1'b1;
      ms_q   <= '0;
      half_q <= '0;
    end else if (busy && tick) begin
      ms_q <= ms_q + 1'b1;
      if (ms_q == INIT_LAST) busy <= 1'b0;
      if (half_q == HALF_LAST) begin
        half_q <= '0;
        square <= ~square;
      end else begin
        half_q <= half_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cp_pulse_timer.sv
module cp_pulse_timer #(
  parameter int unsigned CLKS_PER_MS = 10000,
  parameter int unsigned MSW         = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [MSW-1:0] load_ms,
  input  logic           drive_in,
  input  logic           level_in,
  output logic           active,
  output logic           drive,
  output logic           level,
  output logic           done
);
  logic           tick;
  logic [MSW-1:0] left_q;

  cp_ms_prescale #(.CLKS_PER_MS(CLKS_PER_MS)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (start),
    .ms_tick (tick)
  );

  assign done = active && tick && (left_q == MSW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      drive  <= 1'b0;
      level  <= 1'b0;
      left_q <= '0;
    end else if (start) begin
      active <= 1'b1;
      drive  <= drive_in;
      level  <= level_in;
      left_q <= load_ms;
    end else if (done) begin
      active <= 1'b0;
      drive  <= 1'b0;
      level  <= 1'b0;
      left_q <= '0;
    end else if (active && tick) begin
      left_q <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/chargepump_pulse_ctrl.sv
module chargepump_pulse_ctrl #(
  parameter int unsigned ERR_W          = 8,
  parameter int unsigned CLKS_PER_MS    = 10000,
  parameter int unsigned MS_PER_COUNT   = 5,
  parameter int unsigned INIT_MS        = 20000,
  parameter int unsigned SQ_HALF_MS     = 250,
  parameter bit          POS_DRIVE_HIGH = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pps_tick,
  input  logic             err_valid,
  output logic             err_ready,
  input  logic [ERR_W-1:0] err_value,
  output logic             pump_level,
  output logic             pump_oe,
  output logic             led_on
);
  import cp_pkg::*;

  localparam int unsigned MAX_MAG = 1 << (ERR_W - 1);
  localparam int unsigned MSW     = cp_width(MAX_MAG * MS_PER_COUNT);

  cp_phase_e phase_q;
  logic      pps_pend_q;
  logic      init_busy, init_sq;
  logic      accept;
  logic [ERR_W-1:0] mag;
  logic [MSW-1:0]   load_ms;
  logic      t_active, t_drive, t_level, t_done;
  logic      err_neg, err_zero, lvl_sel;

  cp_start_seq #(
    .CLKS_PER_MS (CLKS_PER_MS),
    .INIT_MS     (INIT_MS),
    .SQ_HALF_MS  (SQ_HALF_MS)
  ) u_start (
    .clk    (clk),
    .rst_n  (rst_n),
    .busy   (init_busy),
    .square (init_sq)
  );

  assign err_neg  = err_value[ERR_W-1];
  assign err_zero = (err_value == '0);
  assign mag      = err_neg ? (~err_value + 1'b1) : err_value;
  assign load_ms  = (err_zero ? MSW'(1) : MSW'(mag)) * MSW'(MS_PER_COUNT);
  assign lvl_sel  = err_neg ? ~POS_DRIVE_HIGH : POS_DRIVE_HIGH;

  assign err_ready = (phase_q == CP_ARMED);
  assign accept    = err_valid && err_ready;

  cp_pulse_timer #(
    .CLKS_PER_MS (CLKS_PER_MS),
    .MSW         (MSW)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept),
    .load_ms  (load_ms),
    .drive_in (~err_zero),
    .level_in (lvl_sel),
    .active   (t_active),
    .drive    (t_drive),
    .level    (t_level),
    .done     (t_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q    <= CP_START;
      pps_pend_q <= 1'b0;
    end else begin
      unique case (phase_q)
        CP_START: if (!init_busy) phase_q <= CP_WAIT;
        CP_WAIT:  if (pps_tick)   phase_q <= CP_ARMED;
        CP_ARMED: if (accept)     phase_q <= CP_PULSE;
        CP_PULSE: begin
          if (pps_tick) pps_pend_q <= 1'b1;
          if (t_done) begin
            phase_q    <= (pps_pend_q || pps_tick) ? CP_ARMED : CP_WAIT;
            pps_pend_q <= 1'b0;
          end
        end
        default: phase_q <= CP_START;
      endcase
    end
  end

  always_comb begin
    if (init_busy) begin
      pump_oe    = 1'b1;
      pump_level = init_sq;
      led_on     = 1'b0;
    end else begin
      pump_oe    = t_active && t_drive;
      pump_level = t_active && t_drive && t_level;
      led_on     = t_active;
    end
  end
endmodule

// File: rtl/chargepump_pulse_ctrl_chk.sv
module chargepump_pulse_ctrl_chk #(
  parameter int unsigned ERR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             err_valid,
  input logic             err_ready,
  input logic [ERR_W-1:0] err_value,
  input logic             pump_oe,
  input logic             pump_level,
  input logic             led_on,
  input logic             init_busy
);
  // R1
  init_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_busy |-> (pump_oe && !led_on && !err_ready));

  // R2
  oe_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pump_oe |-> (init_busy || led_on));

  // R9
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_ready |-> !led_on);

  // R3
  window_from_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(led_on) |-> $past(err_valid && err_ready));

  // R6
  zero_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && err_ready && err_value == '0) |=> (led_on && !pump_oe));

  // R5
  level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pump_oe && !init_busy && $past(pump_oe && !init_busy)) |-> $stable(pump_level));
endmodule

bind chargepump_pulse_ctrl chargepump_pulse_ctrl_chk #(.ERR_W(ERR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .err_valid  (err_valid),
  .err_ready  (err_ready),
  .err_value  (err_value),
  .pump_oe    (pump_oe),
  .pump_level (pump_level),
  .led_on     (led_on),
  .init_busy  (init_busy)
);

// File: tb/chargepump_pulse_ctrl_test.sv
`timescale 1ns/1ps
module chargepump_pulse_ctrl_test;
  localparam int CPM  = 4;
  localparam int MPC  = 5;
  localparam int INIT = 40;
  localparam int HALF = 5;
  localparam bit POL  = 1'b0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pps_tick = 1'b0;
  logic err_valid = 1'b0;
  logic [7:0] err_value = 8'h00;
  logic err_ready, pump_level, pump_oe, led_on;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  bit done_flag = 1'b0;

  always #2.5 clk = ~clk;

  chargepump_pulse_ctrl #(
    .ERR_W(8), .CLKS_PER_MS(CPM), .MS_PER_COUNT(MPC),
    .INIT_MS(INIT), .SQ_HALF_MS(HALF), .POS_DRIVE_HIGH(POL)
  ) uut (
    .clk(clk), .rst_n(rst_n), .pps_tick(pps_tick),
    .err_valid(err_valid), .err_ready(err_ready), .err_value(err_value),
    .pump_level(pump_level), .pump_oe(pump_oe), .led_on(led_on)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
      finish_up();
    end
  end

  function automatic int exp_cycles(input logic signed [7:0] e);
    int m;
    m = (e < 0) ? -int'(e) : int'(e);
    return ((m == 0) ? 1 : m) * MPC * CPM;
  endfunction

  function automatic bit exp_level(input logic signed [7:0] e);
    return (e > 0) ? POL : ~POL;
  endfunction

  task automatic run_error(input logic signed [7:0] e, input bit inject, input bit pps_mid);
    int n = 0, oe_n = 0, bad_lvl = 0, exp_n, quiet_bad = 0;
    exp_n = exp_cycles(e);
    @(negedge clk) pps_tick = 1'b1;
    @(negedge clk) pps_tick = 1'b0;
    check(err_ready == 1'b1, "R3 ready after PPS", int'(err_ready), 1);
    err_valid = 1'b1;
    err_value = e;
    @(negedge clk);
    err_valid = 1'b0;
    err_value = 8'h55;
    check(err_ready == 1'b0, "R9 ready low in window", int'(err_ready), 0);
    while (led_on && n < 4000) begin
      if (pump_oe) begin
        oe_n++;
        if (pump_level !== exp_level(e)) bad_lvl++;
      end
      err_valid = inject && (n == 8);
      pps_tick  = pps_mid && (n == 3);
      n++;
      @(negedge clk);
    end
    err_valid = 1'b0;
    pps_tick  = 1'b0;
    // R7 LED window, R10 prescaled length
    check(n == exp_n, "R7 window length", n, exp_n);
    // R4 drive length, R6 zero gives no drive
    check(oe_n == ((e == 0) ? 0 : exp_n), "R4 drive cycles", oe_n, (e == 0) ? 0 : exp_n);
    check(bad_lvl == 0, "R5 drive polarity", bad_lvl, 0);
    check(pump_oe == 1'b0 && pump_level == 1'b0, "R2 released after pulse",
          int'({pump_oe, pump_level}), 0);
    check(err_ready == pps_mid, "R3 re-arm state", int'(err_ready), int'(pps_mid));
    if (!pps_mid) begin
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (led_on || pump_oe) quiet_bad++;
      end
      if (inject) check(quiet_bad == 0, "R9 late beat ignored", quiet_bad, 0);
    end
  endtask

  initial begin
    int first_tog = -1, end_cyc = -1, toggles = 0, init_bad = 0, c = 0, stray = 0;
    bit prev;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    check(pump_oe == 1'b1 && pump_level == 1'b1 && !led_on && !err_ready,
          "R1 reset state", int'({pump_oe, pump_level, led_on, err_ready}), 4'b1100);
    rst_n = 1'b1;
    prev = pump_level;
    while (end_cyc < 0 && c < 2000) begin
      @(negedge clk);
      c++;
      pps_tick = (c == 30);
      if (pump_oe) begin
        if (led_on || err_ready) init_bad++;
        if (pump_level != prev) begin
          toggles++;
          if (first_tog < 0) first_tog = c;
        end
        prev = pump_level;
      end else begin
        end_cyc = c;
      end
    end
    pps_tick = 1'b0;
    check(end_cyc == INIT * CPM, "R1 start-up length", end_cyc, INIT * CPM);
    check(first_tog == HALF * CPM, "R1 square half period", first_tog, HALF * CPM);
    check(toggles == INIT / HALF - 1, "R1 toggle count", toggles, INIT / HALF - 1);
    check(init_bad == 0, "R1 dark during start-up", init_bad, 0);

    // R8: no PPS -> beats never taken, PPS during start-up was ignored
    err_valid = 1'b1;
    err_value = 8'd20;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (led_on || pump_oe || err_ready) stray++;
    end
    err_valid = 1'b0;
    check(stray == 0, "R8 no PPS no pulse", stray, 0);

    run_error(8'sd127, 1'b0, 1'b0);
    run_error(-8'sd128, 1'b0, 1'b0);
    run_error(8'sd1, 1'b0, 1'b0);
    run_error(-8'sd1, 1'b0, 1'b0);
    run_error(8'sd0, 1'b0, 1'b0);
    run_error(-8'sd3, 1'b1, 1'b0);
    run_error(8'sd6, 1'b0, 1'b1);
    for (int i = 0; i < 16; i++) begin
      logic signed [7:0] r;
      r = 8'($urandom_range(0, 255));
      run_error(r, 1'($urandom_range(0, 1)), 1'b0);
    end
    finish_up();
  end
endmodule